// File: doc/BRIEF.md
# Receiver Bandwidth Tracking Controller

This controller sits in a multicarrier receiver that follows the bandwidth picked by the far-end transmitter without ever talking back to it. After reset it assumes the widest bandwidth, so every interleaved sub-converter and every processing instance is enabled. Once per frame a decoder supplies the level word carried on the low-frequency control subcarriers, which are always received. The controller qualifies that word and waits for the next window boundary. It then keeps the old set of instances alive for a programmable stabilizing interval and switches the rate level and the enable masks one frame after the switch completes.

A frame strobe marks each frame. Between strobes the controller holds its state and ignores its inputs. The window length and the stabilizing interval are counted in frames. They are static configuration inputs.

Top module: `rxbw_track`

## Requirements
- R1: After reset, rate_lvl_o is 0 (full bandwidth), adc_en_o is all ones and proc_en_o is all ones.
- R2: Level code 0 means full, 1 means half and 2 means quarter bandwidth, and code 3 is invalid. At a level l, adc_en_o bit i is set exactly when i is a multiple of 2^l (1111, 0101, 0001 for four converters), and proc_en_o has its lowest N_PROC>>l bits set.
- R3: A level is accepted only when two consecutive frame strobes both carry ctrl_ok_i high and the same valid code. A strobe with ctrl_ok_i low or code 3 breaks the pair.
- R4: Frame strobes are counted from reset in windows of win_len_i strobes, and a value of 0 acts as 1. An accepted change starts switching only at a strobe that closes a window and comes after the acceptance strobe. A word accepted on a closing strobe waits for the next one.
- R5: From the window-closing strobe b until the change is applied, both enable masks equal the union of the old and new level masks, and rate_lvl_o keeps the old level.
- R6: With stab_len_i = S, the new level and its masks alone take effect at strobe b+S+1, one strobe after the S-strobe stabilizing interval has run out.
- R7: While a change is waiting for a boundary or being switched, newly qualified levels are not accepted. Acceptance resumes at the first strobe after the apply strobe.
- R8: A qualified level equal to the current level causes no change of any output.
- R9: Outputs change only on a clock edge where frame_i is high, whatever ctrl_ok_i and ctrl_lvl_i do in other cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | One-cycle strobe per received frame |
| ctrl_ok_i | input | 1 | Control word decoded without error this frame |
| ctrl_lvl_i | input | LVL_W | Decoded bandwidth level code |
| win_len_i | input | WIN_W | Window length in frames (0 acts as 1) |
| stab_len_i | input | STAB_W | Stabilizing interval in frames |
| rate_lvl_o | output | LVL_W | Active rate level |
| adc_en_o | output | N_ADC | Sub-converter enable mask |
| proc_en_o | output | N_PROC | Processing-instance enable mask |

## Verification
Two events can land on the same strobe: the qualification of a new level and the close of a window. The controller must not launch a switch from the word it has just accepted. A window length of 1 makes every strobe a closing strobe, and a sweep of window lengths 0 to 4 against stabilizing lengths 0 to 3 drives both events onto the same strobe many times. The bench judges each strobe against an arithmetic schedule of boundary and apply indices. Qualified words that arrive during a switch also fall on boundary and apply strobes, and the same schedule checks that they are dropped.

// File: rtl/rxbw_pkg.sv
package rxbw_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WAIT   = 2'd1,
    ST_STAB   = 2'd2,
    ST_SETTLE = 2'd3
  } sched_st_e;
endpackage

// File: rtl/rxbw_qual.sv
module rxbw_qual #(
  parameter int LVL_W   = 2,
  parameter int NUM_LVL = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic             ok_i,
  input  logic [LVL_W-1:0] lvl_i,
  output logic             pair_o,
  output logic [LVL_W-1:0] pair_lvl_o
);
  localparam logic [LVL_W-1:0] MAX_LVL = LVL_W'(NUM_LVL - 1);

  logic             cur_ok;
  logic             prev_ok_q;
  logic [LVL_W-1:0] prev_lvl_q;

  assign cur_ok     = ok_i && (lvl_i <= MAX_LVL);
  assign pair_o     = frame_i && cur_ok && prev_ok_q && (lvl_i == prev_lvl_q);
  assign pair_lvl_o = lvl_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_ok_q  <= 1'b0;
      prev_lvl_q <= '0;
    end else if (frame_i) begin
      prev_ok_q  <= cur_ok;
      prev_lvl_q <= lvl_i;
    end
  end
endmodule

// File: rtl/rxbw_win.sv
module rxbw_win #(
  parameter int WIN_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             frame_i,
  input  logic [WIN_W-1:0] win_len_i,
  output logic             bound_o
);
  logic [WIN_W-1:0] cnt_q;
  logic [WIN_W-1:0] last;
  logic             at_last;

  assign last    = (win_len_i == '0) ? '0 : win_len_i - WIN_W'(1);
  assign at_last = (cnt_q >= last);
  assign bound_o = frame_i && at_last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (frame_i) cnt_q <= at_last ? '0 : cnt_q + WIN_W'(1);
  end
endmodule

// File: rtl/rxbw_sched.sv
module rxbw_sched
  import rxbw_pkg::*;
#(
  parameter int LVL_W  = 2,
  parameter int STAB_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              pair_i,
  input  logic [LVL_W-1:0]  pair_lvl_i,
  input  logic              bound_i,
  input  logic [STAB_W-1:0] stab_len_i,
  output logic [LVL_W-1:0]  cur_lvl_o,
  output logic [LVL_W-1:0]  mask_lvl_o
);
  sched_st_e         st_q;
  logic [LVL_W-1:0]  cur_q, pend_q;
  logic [STAB_W-1:0] stab_q;
  logic              switching;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      pend_q <= '0;
      stab_q <= '0;
    end else if (frame_i) begin
      unique case (st_q)
        ST_IDLE: if (pair_i && (pair_lvl_i != cur_q)) begin
          pend_q <= pair_lvl_i;
          st_q   <= ST_WAIT;
        end
        ST_WAIT: if (bound_i) begin
          stab_q <= stab_len_i;
          st_q   <= (stab_len_i == '0) ? ST_SETTLE : ST_STAB;
        end
        ST_STAB: begin
          stab_q <= stab_q - STAB_W'(1);
          if (stab_q == STAB_W'(1)) st_q <= ST_SETTLE;
        end
        ST_SETTLE: begin
          cur_q <= pend_q;
          st_q  <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // nested masks: union is the mask of the wider level
  assign switching  = (st_q == ST_STAB) || (st_q == ST_SETTLE);
  assign cur_lvl_o  = cur_q;
  assign mask_lvl_o = (switching && (pend_q < cur_q)) ? pend_q : cur_q;
endmodule

// File: rtl/rxbw_mask.sv
module rxbw_mask #(
  parameter int LVL_W  = 2,
  parameter int N_ADC  = 4,
  parameter int N_PROC = 8
) (
  input  logic [LVL_W-1:0]  lvl_i,
  output logic [N_ADC-1:0]  adc_en_o,
  output logic [N_PROC-1:0] proc_en_o
);
  logic [31:0] phase_mask;
  logic [31:0] proc_cnt;

  assign phase_mask = (32'd1 << lvl_i) - 32'd1;
  assign proc_cnt   = 32'(N_PROC) >> lvl_i;

  for (genvar g = 0; g < N_ADC; g++) begin : g_adc
    // keep active converters evenly spread in phase
    assign adc_en_o[g] = ((32'(g) & phase_mask) == 32'd0);
  end

  for (genvar g = 0; g < N_PROC; g++) begin : g_proc
    assign proc_en_o[g] = (32'(g) < proc_cnt);
  end
endmodule

// File: rtl/rxbw_track.sv
module rxbw_track #(
  parameter  int N_ADC   = 4,
  parameter  int N_PROC  = 8,
  parameter  int WIN_W   = 4,
  parameter  int STAB_W  = 4,
  localparam int NUM_LVL = $clog2(N_ADC) + 1,
  localparam int LVL_W   = (NUM_LVL > 1) ? $clog2(NUM_LVL) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_i,
  input  logic              ctrl_ok_i,
  input  logic [LVL_W-1:0]  ctrl_lvl_i,
  input  logic [WIN_W-1:0]  win_len_i,
  input  logic [STAB_W-1:0] stab_len_i,
  output logic [LVL_W-1:0]  rate_lvl_o,
  output logic [N_ADC-1:0]  adc_en_o,
  output logic [N_PROC-1:0] proc_en_o
);
  logic             pair;
  logic [LVL_W-1:0] pair_lvl;
  logic             bound;
  logic [LVL_W-1:0] mask_lvl;

  rxbw_qual #(.LVL_W(LVL_W), .NUM_LVL(NUM_LVL)) u_qual (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_i    (frame_i),
    .ok_i       (ctrl_ok_i),
    .lvl_i      (ctrl_lvl_i),
    .pair_o     (pair),
    .pair_lvl_o (pair_lvl)
  );

  rxbw_win #(.WIN_W(WIN_W)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_i   (frame_i),
    .win_len_i (win_len_i),
    .bound_o   (bound)
  );

  rxbw_sched #(.LVL_W(LVL_W), .STAB_W(STAB_W)) u_sched (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .frame_i    (frame_i),
    .pair_i     (pair),
    .pair_lvl_i (pair_lvl),
    .bound_i    (bound),
    .stab_len_i (stab_len_i),
    .cur_lvl_o  (rate_lvl_o),
    .mask_lvl_o (mask_lvl)
  );

  rxbw_mask #(.LVL_W(LVL_W), .N_ADC(N_ADC), .N_PROC(N_PROC)) u_mask (
    .lvl_i     (mask_lvl),
    .adc_en_o  (adc_en_o),
    .proc_en_o (proc_en_o)
  );
endmodule

// File: rtl/rxbw_track_chk.sv
module rxbw_track_chk #(
  parameter int N_ADC  = 4,
  parameter int N_PROC = 8,
  parameter int LVL_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              frame_i,
  input logic [LVL_W-1:0]  rate_lvl_o,
  input logic [N_ADC-1:0]  adc_en_o,
  input logic [N_PROC-1:0] proc_en_o
);
  // R9
  no_change_off_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_i |=> ($stable(rate_lvl_o) && $stable(adc_en_o) && $stable(proc_en_o)));

  // R2
  anchor_units_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> (adc_en_o[0] && proc_en_o[0]));

  // R5
  narrow_only_drops_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_lvl_o > $past(rate_lvl_o)) |-> ((adc_en_o & ~$past(adc_en_o)) == '0));

  // R5
  widen_premasked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_lvl_o < $past(rate_lvl_o)) |-> ((adc_en_o == $past(adc_en_o)) && (proc_en_o == $past(proc_en_o))));

  // R2
  adc_count_pow2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(adc_en_o) != 0 |-> $onehot($countones(adc_en_o)));
endmodule

bind rxbw_track rxbw_track_chk #(.N_ADC(N_ADC), .N_PROC(N_PROC), .LVL_W(LVL_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .frame_i    (frame_i),
  .rate_lvl_o (rate_lvl_o),
  .adc_en_o   (adc_en_o),
  .proc_en_o  (proc_en_o)
);

// File: tb/rxbw_track_tb.sv
module rxbw_track_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       frame = 1'b0;
  logic       ok = 1'b0;
  logic [1:0] lvl = '0;
  logic [3:0] win = 4'd1;
  logic [3:0] stab = 4'd0;
  logic [1:0] rate;
  logic [3:0] adc;
  logic [7:0] proc;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;

  rxbw_track u_dut (
    .clk_i(clk), .rst_ni(rst_n), .frame_i(frame), .ctrl_ok_i(ok),
    .ctrl_lvl_i(lvl), .win_len_i(win), .stab_len_i(stab),
    .rate_lvl_o(rate), .adc_en_o(adc), .proc_en_o(proc)
  );

  function automatic logic [3:0] exp_adc(int l);
    logic [3:0] r;
    for (int i = 0; i < 4; i++) r[i] = ((i % (1 << l)) == 0);
    return r;
  endfunction

  function automatic logic [7:0] exp_proc(int l);
    return 8'((1 << (8 >> l)) - 1);
  endfunction

  // bench schedule state
  int m_n, m_cur, m_pend, m_phase, m_apply, m_prev_ok, m_prev_lvl;

  task automatic check_out(string tag, int ml, int rl);
    checks++;
    if (rate !== 2'(rl) || adc !== exp_adc(ml) || proc !== exp_proc(ml)) begin
      errors++;
      $display("FAIL %s: actual rate=%0d adc=%b proc=%b expected rate=%0d adc=%b proc=%b",
               tag, rate, adc, proc, rl, exp_adc(ml), exp_proc(ml));
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; frame = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    m_n = 0; m_cur = 0; m_pend = 0; m_phase = 0; m_apply = 0;
    m_prev_ok = 0; m_prev_lvl = 0;
    check_out("R1", 0, 0);
  endtask

  task automatic strobe(logic s_ok, logic [1:0] s_lvl);
    int wl, ml;
    bit cur_ok, pair, bnd;
    string tag;
    @(negedge clk);
    frame = 1'b1; ok = s_ok; lvl = s_lvl;
    @(negedge clk);
    frame = 1'b0; ok = ~s_ok; lvl = ~s_lvl;  // scrambled off-strobe (R9)
    wl = (win == 0) ? 1 : int'(win);
    cur_ok = s_ok && (s_lvl != 2'd3);
    pair = cur_ok && m_prev_ok != 0 && (int'(s_lvl) == m_prev_lvl);
    bnd = ((m_n + 1) % wl) == 0;
    tag = "R3";
    if (m_phase != 0 && pair && int'(s_lvl) != m_cur) tag = "R7";
    else if (m_phase == 0 && pair && int'(s_lvl) == m_cur) tag = "R8";
    if (m_phase == 1) begin
      tag = "R4";
      if (bnd) begin m_apply = m_n + int'(stab) + 1; m_phase = 2; tag = "R5"; end
    end else if (m_phase == 2) begin
      tag = "R5";
      if (m_n == m_apply) begin m_cur = m_pend; m_phase = 0; tag = "R6"; end
    end else if (pair && int'(s_lvl) != m_cur) begin
      m_pend = int'(s_lvl); m_phase = 1;
    end
    m_prev_ok = cur_ok; m_prev_lvl = int'(s_lvl); m_n++;
    ml = (m_phase == 2 && m_pend < m_cur) ? m_pend : m_cur;
    check_out(tag, ml, m_cur);
    @(negedge clk);
    check_out("R9", ml, m_cur);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    logic [1:0]  v;
    // R8: repeated full-level words leave everything unchanged
    win = 4'd2; stab = 4'd1;
    do_reset();
    for (int i = 0; i < 4; i++) strobe(1'b1, 2'd0);
    // R2: reach quarter directly, then back to full
    for (int i = 0; i < 8; i++) strobe(1'b1, 2'd2);
    for (int i = 0; i < 8; i++) strobe(1'b1, 2'd0);
    // R4 R5 R6 R7: sweep window and stabilizing lengths
    for (int w = 0; w <= 4; w++) begin
      for (int s = 0; s <= 3; s++) begin
        win = 4'(w); stab = 4'(s);
        do_reset();
        lf = 16'hACE1 ^ 16'(w * 97 + s * 13);
        v = 2'd1;
        for (int k = 0; k < 70; k++) begin
          lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
          if (lf[1:0] == 2'd0) v = lf[3:2];
          strobe(lf[7:4] != 4'd0, v);
        end
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule